// File: doc/BRIEF.md
# Breakpoint Acknowledge Sequencer

This block is the processor-side controller for the breakpoint acknowledge bus cycle. It serves two sources. A software breakpoint request arrives with a 3-bit breakpoint number. A hardware breakpoint arrives as a level on an external breakpoint pin. For either source the block issues a single word read in CPU space. The read encodes the breakpoint number and a trap-kind bit in the low address bits. The block then waits for the bus to end the read with either a data-size acknowledge or a bus error, and it reports one of four outcomes as a one-cycle pulse.

The four outcomes are:
- insert the returned opcode (software breakpoint, acknowledged);
- continue with the next instruction (hardware breakpoint, acknowledged);
- request illegal-instruction exception processing (software breakpoint, bus error);
- request hardware-breakpoint exception processing (hardware breakpoint, bus error).

Both 16-bit and 8-bit data ports are supported. On an 8-bit port the word is fetched as two byte reads on the upper data lane, high byte first.

The sequencer has four states: `ST_IDLE`, `ST_ADDR`, `ST_WAIT_TERM` and `ST_RESULT`. Its transitions are:
- **start**: `ST_IDLE` to `ST_ADDR` when a software request is present, or when a latched hardware request is present and no flush is asserted.
- **strobe**: `ST_ADDR` to `ST_WAIT_TERM`, always.
- **next byte**: `ST_WAIT_TERM` to `ST_ADDR`, on an acknowledge of the high byte on an 8-bit port.
- **terminate**: `ST_WAIT_TERM` to `ST_RESULT`, on a bus error, or on the final acknowledge.
- **report**: `ST_RESULT` to `ST_IDLE`, always.

The breakpoint pin is captured into a pending flag on every clock edge, except while a hardware cycle is being served. A flush clears that flag.

Top module: `bkpt_ack_seq`

## Requirements
- R1: A software request drives the following for the whole read:
  - `fc_o` = 3'b111;
  - `addr_o[19:16]` = 0 (type field);
  - `addr_o[4:2]` = `sw_num`;
  - `addr_o[1]` = 0;
  - every other address bit 0, apart from `addr_o[0]`.
- R2: A hardware request drives the same read, with `addr_o[4:2]` = 3'b111 and `addr_o[1]` = 1.
- R3: On a 16-bit port (`port8`=0), a software read ended by `dsack_i` pulses `insert_o` for one cycle. During that pulse, `opcode_o` equals the `data_i[15:0]` sampled at the terminating edge.
- R4: On an 8-bit port (`port8`=1), the read runs twice. The first pass has `addr_o[0]`=0 and the second has `addr_o[0]`=1. The opcode is {first `data_i[15:8]`, second `data_i[15:8]`}, and `data_i[7:0]` is ignored.
- R5: A software read ended by `berr_i`, on any pass, pulses `illegal_o` and never `insert_o`.
- R6: A hardware read ended by `dsack_i` pulses `cont_o`. The data bus has no effect and `insert_o` stays 0.
- R7: A hardware read ended by `berr_i`, on any pass, pulses `hwexc_o`.
- R8: If `berr_i` and `dsack_i` are both high at the terminating edge, the bus error outcome is taken.
- R9: A high `hw_pin` at a clock edge latches a hardware request. The request is served even if the pin drops in the next cycle. A `flush` at an edge while the request is still pending drops it, and no read starts.
- R10: If a software and a hardware request are pending in the same idle cycle, the software read is served first. The hardware request stays latched and is served afterwards.
- R11: Reset leaves all outputs at 0. `cyc_o` rises one cycle after the request is accepted. A result pulse appears in the cycle after the terminating edge. At most one result output is high at a time, and each result output is high for one cycle only.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sw_req | input | 1 | Software breakpoint request, sampled in idle |
| sw_num | input | 3 | Breakpoint number of the software request |
| hw_pin | input | 1 | External hardware breakpoint pin |
| flush | input | 1 | Pipeline flush; drops a pending hardware request |
| port8 | input | 1 | 1 = 8-bit data port, 0 = 16-bit data port |
| cyc_o | output | 1 | Bus read cycle active |
| fc_o | output | 3 | Function code, 3'b111 during the cycle |
| addr_o | output | ADDR_W (24) | Read address |
| data_i | input | 16 | Read data |
| dsack_i | input | 1 | Data-size acknowledge termination |
| berr_i | input | 1 | Bus error termination |
| insert_o | output | 1 | Pulse: insert `opcode_o` into the pipeline |
| opcode_o | output | 16 | Replacement opcode |
| cont_o | output | 1 | Pulse: continue with the next instruction |
| illegal_o | output | 1 | Pulse: illegal-instruction exception request |
| hwexc_o | output | 1 | Pulse: hardware-breakpoint exception request |

## Verification
The software path is swept over all eight breakpoint numbers, for both port widths, and with the bus error placed on no pass, on the first pass or on the second pass. The data word differs per case and the low data lane carries the inverted byte, so a wrong lane, byte order or number encoding shows up in `opcode_o` or `addr_o`. The hardware path is tried with the same termination placements, using a one-cycle pin pulse that proves the pin is latched. Dedicated patterns cover:
- both terminations in one clock, which checks the precedence rule;
- both request kinds arriving together, which checks the service order;
- a flush that lands on a pending pin request, which checks that the request is dropped.

// File: rtl/bkpt_ack_pkg.sv
package bkpt_ack_pkg;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_ADDR,
        ST_WAIT_TERM,
        ST_RESULT
    } seq_state_t;

    localparam logic [2:0] FC_CPU_SPACE  = 3'b111;
    localparam int         TYPE_W        = 4;
    localparam int         TYPE_LSB      = 16;
    localparam logic [3:0] CPU_TYPE_BKPT = 4'h0;
    localparam logic [2:0] HW_BKPT_NUM   = 3'b111;

endpackage

// File: rtl/bkpt_req_latch.sv
module bkpt_req_latch (
    input  logic clk,
    input  logic rst_n,
    input  logic pin,
    input  logic flush,
    input  logic hw_busy,
    input  logic take,
    output logic pend
);

    logic pend_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_q <= 1'b0;
        end else if (flush || take) begin
            pend_q <= 1'b0;
        end else if (pin && !hw_busy) begin
            pend_q <= 1'b1;
        end
    end

    assign pend = pend_q;

endmodule

// File: rtl/bkpt_addr_gen.sv
module bkpt_addr_gen
    import bkpt_ack_pkg::*;
#(
    parameter int ADDR_W = 24
) (
    input  logic              active,
    input  logic [2:0]        num,
    input  logic              t_bit,
    input  logic              lo_byte,
    output logic [2:0]        fc,
    output logic [ADDR_W-1:0] addr
);

    always_comb begin
        fc   = '0;
        addr = '0;
        if (active) begin
            fc                         = FC_CPU_SPACE;
            addr[TYPE_LSB +: TYPE_W]   = CPU_TYPE_BKPT;
            addr[4:2]                  = num;
            addr[1]                    = t_bit;
            addr[0]                    = lo_byte;
        end
    end

endmodule

// File: rtl/bkpt_word_asm.sv
module bkpt_word_asm #(
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cap,
    input  logic              narrow,
    input  logic              lo_phase,
    input  logic [DATA_W-1:0] data_in,
    output logic [DATA_W-1:0] word
);

    localparam int BYTE_W = DATA_W / 2;

    logic [DATA_W-1:0] word_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            word_q <= '0;
        end else if (cap) begin
            if (!narrow) begin
                word_q <= data_in;
            end else if (!lo_phase) begin
                word_q[DATA_W-1:BYTE_W] <= data_in[DATA_W-1:BYTE_W];
            end else begin
                word_q[BYTE_W-1:0] <= data_in[DATA_W-1:BYTE_W];
            end
        end
    end

    assign word = word_q;

endmodule

// File: rtl/bkpt_ack_seq.sv
module bkpt_ack_seq
    import bkpt_ack_pkg::*;
#(
    parameter int ADDR_W = 24,
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sw_req,
    input  logic [2:0]        sw_num,
    input  logic              hw_pin,
    input  logic              flush,
    input  logic              port8,
    output logic              cyc_o,
    output logic [2:0]        fc_o,
    output logic [ADDR_W-1:0] addr_o,
    input  logic [DATA_W-1:0] data_i,
    input  logic              dsack_i,
    input  logic              berr_i,
    output logic              insert_o,
    output logic [DATA_W-1:0] opcode_o,
    output logic              cont_o,
    output logic              illegal_o,
    output logic              hwexc_o
);

    seq_state_t state_q, state_d;
    logic       is_hw_q;
    logic [2:0] num_q;
    logic       p8_q;
    logic       lo_q;
    logic       berr_q;

    logic hw_pend;
    logic take_hw;
    logic start;
    logic hw_busy;
    logic term_ok;
    logic cap_word;
    logic in_cycle;

    // request arbitration: software first, then a latched, unflushed pin
    assign start   = (state_q == ST_IDLE) && (sw_req || (hw_pend && !flush));
    assign take_hw = (state_q == ST_IDLE) && !sw_req && hw_pend && !flush;
    assign hw_busy = (state_q != ST_IDLE) && is_hw_q;
    assign term_ok = (state_q == ST_WAIT_TERM) && dsack_i && !berr_i;
    assign cap_word = term_ok && !is_hw_q;
    assign in_cycle = (state_q == ST_ADDR) || (state_q == ST_WAIT_TERM);

    bkpt_req_latch u_req (
        .clk     (clk),
        .rst_n   (rst_n),
        .pin     (hw_pin),
        .flush   (flush),
        .hw_busy (hw_busy),
        .take    (take_hw),
        .pend    (hw_pend)
    );

    bkpt_addr_gen #(.ADDR_W(ADDR_W)) u_addr (
        .active  (in_cycle),
        .num     (num_q),
        .t_bit   (is_hw_q),
        .lo_byte (lo_q),
        .fc      (fc_o),
        .addr    (addr_o)
    );

    bkpt_word_asm #(.DATA_W(DATA_W)) u_word (
        .clk      (clk),
        .rst_n    (rst_n),
        .cap      (cap_word),
        .narrow   (p8_q),
        .lo_phase (lo_q),
        .data_in  (data_i),
        .word     (opcode_o)
    );

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (start) state_d = ST_ADDR;
            end
            ST_ADDR: begin
                state_d = ST_WAIT_TERM;
            end
            ST_WAIT_TERM: begin
                if (berr_i) begin
                    state_d = ST_RESULT;
                end else if (dsack_i) begin
                    state_d = (p8_q && !lo_q) ? ST_ADDR : ST_RESULT;
                end
            end
            ST_RESULT: begin
                state_d = ST_IDLE;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // state register and per-cycle context
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            is_hw_q <= 1'b0;
            num_q   <= '0;
            p8_q    <= 1'b0;
            lo_q    <= 1'b0;
            berr_q  <= 1'b0;
        end else begin
            state_q <= state_d;
            if (start) begin
                is_hw_q <= !sw_req;
                num_q   <= sw_req ? sw_num : HW_BKPT_NUM;
                p8_q    <= port8;
                lo_q    <= 1'b0;
                berr_q  <= 1'b0;
            end else if (state_q == ST_WAIT_TERM) begin
                if (berr_i) begin
                    berr_q <= 1'b1;
                end else if (dsack_i && p8_q && !lo_q) begin
                    lo_q <= 1'b1;
                end
            end
        end
    end

    // outputs
    always_comb begin
        cyc_o     = in_cycle;
        insert_o  = 1'b0;
        cont_o    = 1'b0;
        illegal_o = 1'b0;
        hwexc_o   = 1'b0;
        if (state_q == ST_RESULT) begin
            insert_o  = !is_hw_q && !berr_q;
            illegal_o = !is_hw_q &&  berr_q;
            cont_o    =  is_hw_q && !berr_q;
            hwexc_o   =  is_hw_q &&  berr_q;
        end
    end

endmodule

// File: rtl/bkpt_ack_seq_chk.sv
module bkpt_ack_seq_chk #(
    parameter int ADDR_W = 24
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cyc_o,
    input logic [2:0]        fc_o,
    input logic [ADDR_W-1:0] addr_o,
    input logic              dsack_i,
    input logic              berr_i,
    input logic              insert_o,
    input logic              cont_o,
    input logic              illegal_o,
    input logic              hwexc_o
);

    logic any_res;
    assign any_res = insert_o | cont_o | illegal_o | hwexc_o;

    // R1
    cpu_space_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cyc_o |-> (fc_o == 3'b111) && (addr_o[19:16] == 4'h0));

    // R2
    hw_num_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cyc_o && addr_o[1]) |-> (addr_o[4:2] == 3'b111));

    // R3
    insert_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        insert_o |-> $past(cyc_o && dsack_i && !berr_i && !addr_o[1]));

    // R4
    first_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cyc_o) |-> !addr_o[0]);

    // R5
    illegal_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        illegal_o |-> $past(cyc_o && berr_i && !addr_o[1]));

    // R6
    cont_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cont_o |-> $past(cyc_o && dsack_i && !berr_i && addr_o[1]));

    // R7
    hwexc_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        hwexc_o |-> $past(cyc_o && berr_i && addr_o[1]));

    // R11
    result_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({insert_o, cont_o, illegal_o, hwexc_o}));

    // R11
    result_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        any_res |=> !any_res);

    // R11
    no_cyc_in_result_chk: assert property (@(posedge clk) disable iff (!rst_n)
        any_res |-> !cyc_o);

endmodule

bind bkpt_ack_seq bkpt_ack_seq_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .cyc_o     (cyc_o),
    .fc_o      (fc_o),
    .addr_o    (addr_o),
    .dsack_i   (dsack_i),
    .berr_i    (berr_i),
    .insert_o  (insert_o),
    .cont_o    (cont_o),
    .illegal_o (illegal_o),
    .hwexc_o   (hwexc_o)
);

// File: tb/bkpt_ack_seq_test.sv
module bkpt_ack_seq_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        sw_req = 1'b0;
    logic [2:0]  sw_num = '0;
    logic        hw_pin = 1'b0;
    logic        flush = 1'b0;
    logic        port8 = 1'b0;
    logic        cyc_o;
    logic [2:0]  fc_o;
    logic [23:0] addr_o;
    logic [15:0] data_i = '0;
    logic        dsack_i = 1'b0;
    logic        berr_i = 1'b0;
    logic        insert_o;
    logic [15:0] opcode_o;
    logic        cont_o;
    logic        illegal_o;
    logic        hwexc_o;

    int total = 0;
    int bad = 0;

    always #10 clk = ~clk;

    bkpt_ack_seq uut (
        .clk(clk), .rst_n(rst_n), .sw_req(sw_req), .sw_num(sw_num),
        .hw_pin(hw_pin), .flush(flush), .port8(port8), .cyc_o(cyc_o),
        .fc_o(fc_o), .addr_o(addr_o), .data_i(data_i), .dsack_i(dsack_i),
        .berr_i(berr_i), .insert_o(insert_o), .opcode_o(opcode_o),
        .cont_o(cont_o), .illegal_o(illegal_o), .hwexc_o(hwexc_o)
    );

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    // Serve one acknowledge read. berr_at: 0 = none, n = bus error on pass n.
    task automatic serve(input bit hw, input logic [2:0] num, input bit p8,
                         input int berr_at, input bit both,
                         input logic [15:0] word, input string req);
        int passes = p8 ? 2 : 1;
        bit saw_berr = 1'b0;
        logic [3:0] expv;
        logic [31:0] exp_a;
        for (int p = 0; p < passes; p++) begin
            int waited = 0;
            while (!cyc_o && waited < 40) begin
                @(negedge clk);
                waited++;
            end
            if (!cyc_o) begin
                chk(req, "cycle start", 32'd0, 32'd1);
                return;
            end
            hw_pin = 1'b0;
            exp_a = ((hw ? 32'd7 : 32'(num)) << 2) | (32'(hw) << 1) | 32'(p);
            chk(hw ? "R2" : "R1", "fc", 32'(fc_o), 32'h7);
            chk(hw ? "R2" : "R1", "addr", 32'(addr_o), exp_a);
            if (p8) data_i = (p == 0) ? {word[15:8], ~word[15:8]} : {word[7:0], ~word[7:0]};
            else    data_i = word;
            if (berr_at == p + 1) begin
                berr_i  = 1'b1;
                dsack_i = both;
            end else begin
                dsack_i = 1'b1;
            end
            @(negedge clk);
            @(negedge clk);
            dsack_i = 1'b0;
            berr_i  = 1'b0;
            data_i  = 16'hA5A5;
            if (berr_at == p + 1) begin
                saw_berr = 1'b1;
                break;
            end
        end
        if (hw) expv = saw_berr ? 4'b0001 : 4'b0100;
        else    expv = saw_berr ? 4'b0010 : 4'b1000;
        chk(req, "result", 32'({insert_o, cont_o, illegal_o, hwexc_o}), 32'(expv));
        if (!hw && !saw_berr) chk(req, "opcode", 32'(opcode_o), 32'(word));
        @(negedge clk);
        chk("R11", "pulse ends", 32'({insert_o, cont_o, illegal_o, hwexc_o}), 32'd0);
    endtask

    task automatic sw_start(input logic [2:0] n, input bit p8);
        @(negedge clk);
        port8  = p8;
        sw_num = n;
        sw_req = 1'b1;
        @(negedge clk);
        sw_req = 1'b0;
        chk("R11", "cyc after accept", 32'(cyc_o), 32'd1);
    endtask

    task automatic hw_pulse(input bit p8);
        @(negedge clk);
        port8  = p8;
        hw_pin = 1'b1;
        @(negedge clk);
        hw_pin = 1'b0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        bad++;
        $display("FAIL R11 watchdog: actual=timeout expected=done");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic [15:0] w;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R11", "reset outputs",
            32'({cyc_o, insert_o, cont_o, illegal_o, hwexc_o}), 32'd0);
        chk("R11", "reset addr", 32'(addr_o), 32'd0);

        // software sweep: R1, R3, R4, R5
        for (int n = 0; n < 8; n++) begin
            for (int p8 = 0; p8 < 2; p8++) begin
                for (int b = 0; b <= p8 + 1; b++) begin
                    w = 16'h4AC3 ^ (16'(n) * 16'h1357) ^ (16'(p8) << 15);
                    sw_start(3'(n), p8[0]);
                    serve(1'b0, 3'(n), p8[0], b, 1'b0, w,
                          (b != 0) ? "R5" : (p8 != 0 ? "R4" : "R3"));
                end
            end
        end

        // hardware sweep: R2, R6, R7, R9 (one-cycle pin pulse is latched)
        for (int p8 = 0; p8 < 2; p8++) begin
            for (int b = 0; b <= p8 + 1; b++) begin
                hw_pulse(p8[0]);
                serve(1'b1, 3'd7, p8[0], b, 1'b0, 16'h9E21,
                      (b != 0) ? "R7" : "R6");
            end
        end
        hw_pulse(1'b0);
        serve(1'b1, 3'd7, 1'b0, 0, 1'b0, 16'h1234, "R9");

        // R8: both terminations in one clock
        sw_start(3'd3, 1'b0);
        serve(1'b0, 3'd3, 1'b0, 1, 1'b1, 16'h7777, "R8");
        hw_pulse(1'b1);
        serve(1'b1, 3'd7, 1'b1, 2, 1'b1, 16'h7777, "R8");

        // R10: software wins, hardware served afterwards
        @(negedge clk);
        port8  = 1'b0;
        hw_pin = 1'b1;
        @(negedge clk);
        hw_pin = 1'b0;
        sw_num = 3'd2;
        sw_req = 1'b1;
        @(negedge clk);
        sw_req = 1'b0;
        serve(1'b0, 3'd2, 1'b0, 0, 1'b0, 16'hBEEF, "R10");
        serve(1'b1, 3'd7, 1'b0, 0, 1'b0, 16'hBEEF, "R10");

        // R9: flush drops a pending pin request
        @(negedge clk);
        hw_pin = 1'b1;
        @(negedge clk);
        hw_pin = 1'b0;
        flush  = 1'b1;
        @(negedge clk);
        flush  = 1'b0;
        begin
            int seen = 0;
            for (int i = 0; i < 8; i++) begin
                @(negedge clk);
                if (cyc_o) seen++;
            end
            chk("R9", "flushed request starts no cycle", 32'(seen), 32'd0);
        end

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule